// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the APB-facing register file of a byte-wide UART. Software places a byte into a single-entry transmit holding register and takes bytes out of a single-entry receive holding register. A serializer pulls transmit bytes through a valid/ready handshake, and a deserializer pushes received bytes with a one-cycle strobe. The block records full and overrun conditions and raises interrupts for transmit-done, receive, and both overruns. It also produces a baud tick from a programmable divisor and answers a fixed set of read-only identification words.

The two overrun interrupt flags are not stored separately. Each one is the sticky overrun status gated by its enable. Clearing an overrun interrupt therefore clears the underlying status bit. The bus is zero-wait-state and never signals an error.

Top module: `uart_apb_regs`

## Requirements
- R1: After a synchronous reset, the status word (0x04), control word (0x08), interrupt word (0x0C), divisor (0x10) and both byte buffers read as zero. tx_valid, every interrupt output and baud_tick are low.
- R2: A write to the control word keeps only pwdata[6:0]. A write to the divisor keeps only pwdata[19:0]. Both read back at their offsets.
- R3: Reads from word offsets 0xFD0 to 0xFFC return, in address order, 0x04,0x00,0x00,0x00,0x21,0xB8,0x1B,0x00,0x0D,0xF0,0x05,0xB1. Writes there have no effect. Unmapped offsets read zero. pready is always 1 and pslverr is always 0.
- R4: A write to offset 0x00 while status bit 0 (transmit full) is clear sets that bit and presents pwdata[7:0] on tx_byte. tx_valid is high only while transmit full and control bit 0 (transmit enable) are both set.
- R5: A cycle with tx_valid and tx_ready both high clears transmit full. It sets interrupt bit 0 only when control bit 2 is set.
- R6: A write to offset 0x00 while transmit full is set sets status bit 2 (transmit overrun) and replaces the pending byte.
- R7: A receive strobe while control bit 1 (receive enable) is clear is discarded. Status bit 1 stays clear and the receive buffer keeps its value.
- R8: A receive strobe with receive enabled stores rx_byte and sets status bit 1 (receive full). If receive full was already set, it also sets status bit 3 (receive overrun). Interrupt bit 1 is set when control bit 3 is set.
- R9: A read of offset 0x00 returns the receive buffer and clears receive full.
- R10: A write to the status word clears bits 2 and 3 where pwdata has ones. Bits 0 and 1 are unaffected.
- R11: Interrupt bits 0 and 1 clear on write-one. Interrupt bits 2 and 3 always equal status bits 2 and 3 ANDed with control bits 4 and 5. Writing one to interrupt bit 2 or 3 clears the matching status overrun bit.
- R12: irq_tx, irq_rx, irq_txovr and irq_rxovr follow interrupt bits 0 to 3 respectively. irq_any is their OR.
- R13: With a divisor of 16 or more, baud_tick pulses once every divisor cycles. With a divisor below 16, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address within the 4 KB window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tx_byte | output | 8 | Pending transmit byte |
| tx_valid | output | 1 | Transmit byte available to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_byte | input | 8 | Received byte |
| rx_strobe | input | 1 | One-cycle pulse: rx_byte is valid |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |
| baud_tick | output | 1 | One-cycle pulse at the baud rate |

## Verification
A corrupt full flag shows at the ports within one cycle of the next bus access or handshake. If transmit full is lost, tx_valid drops and the next data write no longer reports an overrun. If receive full sticks, the next receive strobe raises a false overrun. Interrupt state that is wrong appears on the irq pins in the same cycle it is latched, because those pins decode flops directly. A divisor counter that slips shows up as a gap of the wrong length between two consecutive baud ticks.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int REG_ADDR_W = 12;
  localparam int WORD_W     = REG_ADDR_W - 2;
  localparam int CTRL_W     = 7;

  // word addresses (byte address >> 2)
  localparam logic [WORD_W-1:0] WA_DATA  = 10'h000;
  localparam logic [WORD_W-1:0] WA_STAT  = 10'h001;
  localparam logic [WORD_W-1:0] WA_CTRL  = 10'h002;
  localparam logic [WORD_W-1:0] WA_INTS  = 10'h003;
  localparam logic [WORD_W-1:0] WA_BAUD  = 10'h004;
  localparam logic [WORD_W-1:0] WA_ID_LO = 10'h3F4;
  localparam logic [WORD_W-1:0] WA_ID_HI = 10'h3FF;

  // control bit positions
  localparam int C_TX_EN  = 0;
  localparam int C_RX_EN  = 1;
  localparam int C_TX_IE  = 2;
  localparam int C_RX_IE  = 3;
  localparam int C_TXO_IE = 4;
  localparam int C_RXO_IE = 5;
endpackage

// File: rtl/uart_id_rom.sv
module uart_id_rom (
  input  logic [3:0] idx,
  output logic [7:0] id_val
);
  always_comb begin
    case (idx)
      4'd0:    id_val = 8'h04;
      4'd4:    id_val = 8'h21;
      4'd5:    id_val = 8'hB8;
      4'd6:    id_val = 8'h1B;
      4'd8:    id_val = 8'h0D;
      4'd9:    id_val = 8'hF0;
      4'd10:   id_val = 8'h05;
      4'd11:   id_val = 8'hB1;
      default: id_val = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] ONE_V = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             div_ok;

  assign div_ok = (div >= MIN_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!div_ok) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div - ONE_V) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + ONE_V;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs
  import uart_regs_pkg::*;
#(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [REG_ADDR_W-1:0] paddr,
  input  logic [31:0]           pwdata,
  output logic [31:0]           prdata,
  output logic                  pready,
  output logic                  pslverr,
  output logic [7:0]            tx_byte,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  input  logic [7:0]            rx_byte,
  input  logic                  rx_strobe,
  output logic                  irq_tx,
  output logic                  irq_rx,
  output logic                  irq_txovr,
  output logic                  irq_rxovr,
  output logic                  irq_any,
  output logic                  baud_tick
);
  logic [WORD_W-1:0] word;
  logic              wr_en, rd_en, id_hit;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  bauddiv_q;
  logic [7:0]        txbuf_q, rxbuf_q, id_val;
  logic              txfull_q, rxfull_q, txovr_q, rxovr_q;
  logic              int_tx_q, int_rx_q;
  logic              tx_accept, rx_take;
  logic [3:0]        ints;
  logic              unused_bits;

  assign word      = paddr[REG_ADDR_W-1:2];
  assign wr_en     = psel & penable & pwrite;
  assign rd_en     = psel & penable & ~pwrite;
  assign id_hit    = (word >= WA_ID_LO) && (word <= WA_ID_HI);
  assign tx_valid  = txfull_q & ctrl_q[C_TX_EN];
  assign tx_accept = tx_valid & tx_ready;
  assign rx_take   = rx_strobe & ctrl_q[C_RX_EN];
  assign tx_byte   = txbuf_q;
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;
  assign unused_bits = ^{paddr[1:0], pwdata[31:DIV_W]};

  // overrun interrupt bits are live products, not stored
  assign ints = {rxovr_q & ctrl_q[C_RXO_IE], txovr_q & ctrl_q[C_TXO_IE], int_rx_q, int_tx_q};

  assign irq_tx    = ints[0];
  assign irq_rx    = ints[1];
  assign irq_txovr = ints[2];
  assign irq_rxovr = ints[3];
  assign irq_any   = |ints;

  uart_id_rom u_id (
    .idx    (word[3:0] - 4'h4),
    .id_val (id_val)
  );

  uart_baud_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .div  (bauddiv_q),
    .tick (baud_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bauddiv_q <= '0;
      txbuf_q   <= '0;
      rxbuf_q   <= '0;
      txfull_q  <= 1'b0;
      rxfull_q  <= 1'b0;
      txovr_q   <= 1'b0;
      rxovr_q   <= 1'b0;
      int_tx_q  <= 1'b0;
      int_rx_q  <= 1'b0;
    end else begin
      // software clears first, hardware sets below take priority
      if (wr_en && (word == WA_STAT || word == WA_INTS)) begin
        if (pwdata[2]) txovr_q <= 1'b0;
        if (pwdata[3]) rxovr_q <= 1'b0;
      end
      if (wr_en && word == WA_INTS) begin
        if (pwdata[0]) int_tx_q <= 1'b0;
        if (pwdata[1]) int_rx_q <= 1'b0;
      end
      if (wr_en && word == WA_CTRL) ctrl_q    <= pwdata[CTRL_W-1:0];
      if (wr_en && word == WA_BAUD) bauddiv_q <= pwdata[DIV_W-1:0];

      // transmit side
      if (wr_en && word == WA_DATA) begin
        txbuf_q  <= pwdata[7:0];
        txfull_q <= 1'b1;
        if (txfull_q && !tx_accept) txovr_q <= 1'b1;
      end else if (tx_accept) begin
        txfull_q <= 1'b0;
      end
      if (tx_accept && ctrl_q[C_TX_IE]) int_tx_q <= 1'b1;

      // receive side
      if (rd_en && word == WA_DATA) rxfull_q <= 1'b0;
      if (rx_take) begin
        rxbuf_q  <= rx_byte;
        rxfull_q <= 1'b1;
        if (rxfull_q) rxovr_q <= 1'b1;
        if (ctrl_q[C_RX_IE]) int_rx_q <= 1'b1;
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (id_hit) begin
        prdata = {24'b0, id_val};
      end else begin
        case (word)
          WA_DATA: prdata = {24'b0, rxbuf_q};
          WA_STAT: prdata = {28'b0, rxovr_q, txovr_q, rxfull_q, txfull_q};
          WA_CTRL: prdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
          WA_INTS: prdata = {28'b0, ints};
          WA_BAUD: prdata = {{(32-DIV_W){1'b0}}, bauddiv_q};
          default: prdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_apb_regs_chk.sv
module uart_apb_regs_chk #(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [11:0]      paddr,
  input logic             pready,
  input logic             pslverr,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_strobe,
  input logic             baud_tick,
  input logic [6:0]       ctrl_q,
  input logic             txfull_q,
  input logic             rxfull_q,
  input logic             txovr_q,
  input logic             rxovr_q,
  input logic             int_tx_q,
  input logic [DIV_W-1:0] bauddiv_q
);
  logic any_wr, data_wr, data_rd;
  assign any_wr  = psel && penable && pwrite;
  assign data_wr = any_wr && (paddr[11:2] == 10'h000);
  assign data_rd = psel && penable && !pwrite && (paddr[11:2] == 10'h000);

  AST_BUS_OKAY: assert property (@(posedge clk) disable iff (rst)
    pready && !pslverr); // R3
  AST_TXV_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !any_wr) |=> tx_valid); // R4
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !data_wr) |=> !txfull_q); // R5
  AST_TXINT_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(int_tx_q) |-> $past(ctrl_q[2])); // R5
  AST_TXOVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (txovr_q && !any_wr) |=> txovr_q); // R6
  AST_RXOVR_SETS: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && ctrl_q[1] && rxfull_q) |=> rxovr_q); // R8
  AST_RXFULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rx_strobe) |=> !rxfull_q); // R9
  AST_BAUD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bauddiv_q < DIV_W'(MIN_DIV)) |=> !baud_tick); // R13
endmodule

bind uart_apb_regs uart_apb_regs_chk #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pready    (pready),
  .pslverr   (pslverr),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_strobe (rx_strobe),
  .baud_tick (baud_tick),
  .ctrl_q    (ctrl_q),
  .txfull_q  (txfull_q),
  .rxfull_q  (rxfull_q),
  .txovr_q   (txovr_q),
  .rxovr_q   (rxovr_q),
  .int_tx_q  (int_tx_q),
  .bauddiv_q (bauddiv_q)
);

// File: tb/uart_apb_regs_bench.sv
`timescale 1ns/1ps
module uart_apb_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_strobe = 1'b0;
  logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any, baud_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  uart_apb_regs u_uart_apb_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr),
    .irq_rxovr(irq_rxovr), .irq_any(irq_any), .baud_tick(baud_tick)
  );

  // {write, addr[11:0], wdata[31:0], expected read[31:0]}
  localparam int NV = 25;
  localparam logic [76:0] VEC [0:NV-1] = '{
    {1'b0, 12'h004, 32'h0,        32'h0},
    {1'b0, 12'h008, 32'h0,        32'h0},
    {1'b0, 12'h010, 32'h0,        32'h0},
    {1'b0, 12'h00C, 32'h0,        32'h0},
    {1'b1, 12'h008, 32'hFFFFFFFF, 32'h0},
    {1'b0, 12'h008, 32'h0,        32'h7F},
    {1'b1, 12'h008, 32'h0,        32'h0},
    {1'b1, 12'h010, 32'hFFFFFFFF, 32'h0},
    {1'b0, 12'h010, 32'h0,        32'hFFFFF},
    {1'b1, 12'h010, 32'h0,        32'h0},
    {1'b1, 12'hFD0, 32'hDEAD,     32'h0},
    {1'b0, 12'hFD0, 32'h0,        32'h04},
    {1'b0, 12'hFD4, 32'h0,        32'h00},
    {1'b0, 12'hFD8, 32'h0,        32'h00},
    {1'b0, 12'hFDC, 32'h0,        32'h00},
    {1'b0, 12'hFE0, 32'h0,        32'h21},
    {1'b0, 12'hFE4, 32'h0,        32'hB8},
    {1'b0, 12'hFE8, 32'h0,        32'h1B},
    {1'b0, 12'hFEC, 32'h0,        32'h00},
    {1'b0, 12'hFF0, 32'h0,        32'h0D},
    {1'b0, 12'hFF4, 32'h0,        32'hF0},
    {1'b0, 12'hFF8, 32'h0,        32'h05},
    {1'b0, 12'hFFC, 32'h0,        32'hB1},
    {1'b0, 12'h014, 32'h0,        32'h0},
    {1'b0, 12'h800, 32'h0,        32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1 rd = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    apb(1'b1, a, d, dummy);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    apb(1'b0, a, 32'h0, v);
    chk(req, v, exp);
  endtask

  task automatic tx_take();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_strobe = 1'b1; rx_byte = b;
    @(negedge clk); rx_strobe = 1'b0;
  endtask

  task automatic wait_tick();
    for (int t = 0; t < 200 && !baud_tick; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tick_gap(output int gap);
    gap = 1;
    while (!baud_tick && gap < 200) begin @(negedge clk); gap++; end
  endtask

  function automatic string tag_of(input logic [11:0] a);
    if (a == 12'h008 || a == 12'h010) return "R2";
    if (a >= 12'hFD0 || a > 12'h010)  return "R3";
    return "R1";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (R1..R13 incomplete): actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int gap, ticks;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 port state out of reset
    chk("R1 outputs", {tx_valid, irq_any, irq_tx, irq_rx, irq_txovr, irq_rxovr, baud_tick}, 32'h0);
    chk("R3 pready/pslverr", {pready, pslverr}, 32'h2);

    for (int i = 0; i < NV; i++) begin
      apb(VEC[i][76], VEC[i][75:64], VEC[i][63:32], v);
      if (!VEC[i][76]) chk(tag_of(VEC[i][75:64]), v, VEC[i][31:0]);
    end

    // R4 transmit load with transmit disabled
    wr32(12'h000, 32'h5A);
    rd_chk("R4 txfull", 12'h004, 32'h1);
    chk("R4 tx_byte", tx_byte, 32'h5A);
    chk("R4 tx_valid gated", tx_valid, 32'h0);
    tx_take();
    rd_chk("R4 no send while disabled", 12'h004, 32'h1);
    // R6 overrun replaces byte
    wr32(12'h000, 32'hA5);
    rd_chk("R6 overrun status", 12'h004, 32'h5);
    chk("R6 byte replaced", tx_byte, 32'hA5);
    // R11 live overrun interrupt, R12 pins
    wr32(12'h008, 32'h15);
    rd_chk("R11 live txo int", 12'h00C, 32'h4);
    chk("R12 irq pins", {irq_any, irq_txovr, irq_rxovr, irq_rx, irq_tx}, 32'h18);
    chk("R4 tx_valid", tx_valid, 32'h1);
    // R5 accept sets tx int
    tx_take();
    rd_chk("R5 txfull cleared", 12'h004, 32'h4);
    rd_chk("R5 tx int set", 12'h00C, 32'h5);
    chk("R12 irq_tx", irq_tx, 32'h1);
    // R11 clearing overrun interrupt clears status
    wr32(12'h00C, 32'h4);
    rd_chk("R11 status overrun cleared", 12'h004, 32'h0);
    rd_chk("R11 tx int kept", 12'h00C, 32'h1);
    wr32(12'h00C, 32'h1);
    chk("R12 irq_any low", irq_any, 32'h0);
    // R5 no interrupt without enable
    wr32(12'h008, 32'h01);
    wr32(12'h000, 32'h33);
    tx_take();
    rd_chk("R5 drained", 12'h004, 32'h0);
    rd_chk("R5 no tx int", 12'h00C, 32'h0);
    // R10 status W1C keeps read-only bits
    wr32(12'h008, 32'h00);
    wr32(12'h000, 32'h11);
    wr32(12'h000, 32'h22);
    rd_chk("R6 overrun again", 12'h004, 32'h5);
    wr32(12'h004, 32'hF);
    rd_chk("R10 W1C", 12'h004, 32'h1);
    wr32(12'h008, 32'h01);
    tx_take();
    rd_chk("R10 drain", 12'h004, 32'h0);
    // R7 receive disabled
    wr32(12'h008, 32'h00);
    rx_push(8'h77);
    rd_chk("R7 no rxfull", 12'h004, 32'h0);
    rd_chk("R7 buffer untouched", 12'h000, 32'h0);
    // R8 receive and overrun
    wr32(12'h008, 32'h2A);
    rx_push(8'h41);
    rd_chk("R8 rxfull", 12'h004, 32'h2);
    rd_chk("R8 rx int", 12'h00C, 32'h2);
    chk("R12 irq_rx", irq_rx, 32'h1);
    rx_push(8'h42);
    rd_chk("R8 rx overrun", 12'h004, 32'hA);
    rd_chk("R8 rxo int", 12'h00C, 32'hA);
    chk("R12 irq_rxovr", irq_rxovr, 32'h1);
    // R9 data read
    rd_chk("R9 data", 12'h000, 32'h42);
    rd_chk("R9 rxfull cleared", 12'h004, 32'h8);
    // R11 clear all
    wr32(12'h00C, 32'hF);
    rd_chk("R11 status after clear", 12'h004, 32'h0);
    rd_chk("R11 ints after clear", 12'h00C, 32'h0);
    chk("R12 irq_any cleared", irq_any, 32'h0);
    // R13 baud tick
    wr32(12'h010, 32'd15);
    ticks = 0;
    for (int t = 0; t < 64; t++) begin @(negedge clk); if (baud_tick) ticks++; end
    chk("R13 quiet below 16", ticks, 32'h0);
    wr32(12'h010, 32'd16);
    wait_tick(); wait_tick();
    tick_gap(gap);
    chk("R13 period 16", gap, 32'd16);
    wr32(12'h010, 32'd20);
    wait_tick(); wait_tick();
    tick_gap(gap);
    chk("R13 period 20", gap, 32'd20);
    // R1 reset mid-run
    wr32(12'h008, 32'h3F);
    wr32(12'h000, 32'h99);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 tx_valid after reset", tx_valid, 32'h0);
    chk("R1 tx_byte after reset", tx_byte, 32'h0);
    rd_chk("R1 status after reset", 12'h004, 32'h0);
    rd_chk("R1 ctrl after reset", 12'h008, 32'h0);
    rd_chk("R1 divisor after reset", 12'h010, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule